// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Claim and Complete

This block collects up to 31 level-sensitive interrupt inputs and drives one interrupt request line to a single processor. Each input has a 3-bit priority and an enable bit. A shared threshold sets the priority level that an input must exceed before it can interrupt. Each input has a gateway with a pending latch. The arbiter picks the eligible pending input with the highest priority. Software reads a claim address to take ownership of the winner, and it writes the same ID back to that address when its handler finishes.

Access goes through a plain synchronous register port with address, write data, write strobe, read strobe and read data. Read data is registered and is valid in the cycle after the read strobe. Reading the claim address is destructive. The returned input leaves arbitration and its gateway stays shut until software writes that ID back as complete. ID 0 has no input, so a claim value of 0 always means that nothing was waiting.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority, the threshold, all enable bits and all pending and claimed state are zero, `eip_o` is low, and reading any register returns 0.
- R2: The priority of input n is a 3-bit register at byte address 4*n for n in 1..31. It is written from `wdata_i[2:0]` and reads back zero-extended. The threshold is a 3-bit register at 0x3000 with the same encoding.
- R3: The enable word at 0x2000 holds the enable for input n in bit n, and bit 0 always reads 0. The pending word at 0x1000 shows the pending latch of input n in bit n. It is read-only, so writes to it have no effect.
- R4: When its input is high and it is not claimed, an input's pending latch sets on the next clock. It stays set after the input falls, until the input is claimed.
- R5: `eip_o` is high exactly when some input is pending, enabled, not claimed, and has a priority strictly greater than the threshold.
- R6: A read at 0x3004 returns, on the next cycle, the ID of the eligible input with the highest priority, with ties going to the lowest ID. It returns 0 when no input is eligible.
- R7: A claim read clears the winner's pending latch and marks it claimed. While claimed, the input is never returned again, its pending bit reads 0 whatever its input does, and it does not raise `eip_o`.
- R8: Writing an ID to 0x3004 releases that input if it is claimed. A held-high input then becomes pending again one cycle later. Writing an ID that is not currently claimed changes nothing.
- R9: An input with priority 0 never interrupts and is never claimed. With threshold 7 nothing can interrupt.
- R10: Reads of addresses outside the map return 0. This includes priority slot 0, addresses at or above 4*32 below 0x1000, non-word-aligned addresses, and words next to the pending, enable and threshold registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 31 | Level interrupt inputs, bit n-1 is input ID n |
| addr_i | input | 16 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data, valid the cycle after `re_i` |
| eip_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that a claim read and a write to the claim address never happen in the same cycle. They also assume that the strobes are zero-valued, not unknown, once reset is released. The bench drives only one bus operation per cycle, each for one clock, and it changes inputs only on the falling edge. The claim-read properties therefore always see a clean claim with no completion in the same cycle. The sweeps run one input through every priority and threshold pair, and then drain all 31 inputs held high, with a bench model of the ownership set.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned PEND_OFS  = 32'h1000;
  localparam int unsigned EN_OFS    = 32'h2000;
  localparam int unsigned THR_OFS   = 32'h3000;
  localparam int unsigned CLAIM_OFS = 32'h3004;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic claimed_o
);
  logic pend_q, pend_d, clm_q, clm_d;

  always_comb begin
    pend_d = pend_q;
    clm_d  = clm_q;
    if (claim_i) begin
      pend_d = 1'b0;
      clm_d  = 1'b1;
    end else begin
      if (complete_i && clm_q) clm_d  = 1'b0;
      if (src_i && !clm_q)     pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      clm_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      clm_q  <= clm_d;
    end
  end

  assign pending_o = pend_q;
  assign claimed_o = clm_q;
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int unsigned NSRC   = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5
) (
  input  logic [NSRC-1:0]        elig_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]      thr_i,
  output logic [ID_W-1:0]        win_id_o,
  output logic                   win_valid_o
);
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;

  always_comb begin
    best_p  = thr_i;
    best_id = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (elig_i[k] && (prio_i[k*PRIO_W +: PRIO_W] > best_p)) begin
        best_p  = prio_i[k*PRIO_W +: PRIO_W];
        best_id = ID_W'(k + 1);
      end
    end
  end

  assign win_id_o    = best_id;
  assign win_valid_o = (best_id != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NSRC   = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              eip_o
);
  import prio_irq_pkg::*;

  localparam int unsigned ID_W = $clog2(NSRC + 1);

  logic rst_n;
  logic [NSRC-1:0] pend, clm, en_q, en_d, claim_vec, compl_vec, prio_we;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [PRIO_W-1:0] thr_q;
  logic [ID_W-1:0]   win_id, idx;
  logic              win_valid, is_prio, claim_rd, claim_take, compl_wr;
  logic              en_we, thr_we;
  logic [DATA_W-1:0] rd_d, rd_q;

  irq_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  // address decode
  assign idx     = addr_i[ID_W+1:2];
  assign is_prio = (addr_i[ADDR_W-1:ID_W+2] == '0) && (addr_i[1:0] == 2'b00)
                   && (idx != '0) && ({1'b0, idx} <= (ID_W+1)'(NSRC));
  assign claim_rd   = re_i && (addr_i == ADDR_W'(CLAIM_OFS));
  assign compl_wr   = we_i && (addr_i == ADDR_W'(CLAIM_OFS));
  assign claim_take = claim_rd && win_valid;
  assign en_we      = we_i && (addr_i == ADDR_W'(EN_OFS));
  assign thr_we     = we_i && (addr_i == ADDR_W'(THR_OFS));

  generate
    for (genvar n = 0; n < NSRC; n++) begin : g_src
      logic [PRIO_W-1:0] prio_q;

      assign claim_vec[n] = claim_take && (win_id == ID_W'(n + 1));
      assign compl_vec[n] = compl_wr && (wdata_i == DATA_W'(n + 1));
      assign prio_we[n]   = we_i && is_prio && (idx == ID_W'(n + 1));

      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n)          prio_q <= '0;
        else if (prio_we[n]) prio_q <= wdata_i[PRIO_W-1:0];
      end

      assign prio_flat[n*PRIO_W +: PRIO_W] = prio_q;

      irq_gateway u_gw (
        .clk_i      (clk_i),
        .rst_ni     (rst_n),
        .src_i      (src_i[n]),
        .claim_i    (claim_vec[n]),
        .complete_i (compl_vec[n]),
        .pending_o  (pend[n]),
        .claimed_o  (clm[n])
      );
    end
  endgenerate

  assign en_d = wdata_i[NSRC:1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (thr_we) thr_q <= wdata_i[PRIO_W-1:0];
    end
  end

  irq_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
    .elig_i      (pend & en_q),
    .prio_i      (prio_flat),
    .thr_i       (thr_q),
    .win_id_o    (win_id),
    .win_valid_o (win_valid)
  );

  // read mux
  always_comb begin
    rd_d = '0;
    if (is_prio) begin
      for (int k = 0; k < NSRC; k++)
        if (idx == ID_W'(k + 1)) rd_d = DATA_W'(prio_flat[k*PRIO_W +: PRIO_W]);
    end else if (addr_i == ADDR_W'(PEND_OFS)) begin
      rd_d = DATA_W'({pend, 1'b0});
    end else if (addr_i == ADDR_W'(EN_OFS)) begin
      rd_d = DATA_W'({en_q, 1'b0});
    end else if (addr_i == ADDR_W'(THR_OFS)) begin
      rd_d = DATA_W'(thr_q);
    end else if (addr_i == ADDR_W'(CLAIM_OFS)) begin
      rd_d = DATA_W'(win_id);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)    rd_q <= '0;
    else if (re_i) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
  assign eip_o   = win_valid;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NSRC   = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              re_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              eip_o,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   clm,
  input logic [PRIO_W-1:0] thr_q
);
  import prio_irq_pkg::*;

  logic claim_rd, claim_wr;
  assign claim_rd = re_i && (addr_i == ADDR_W'(CLAIM_OFS));
  assign claim_wr = we_i && (addr_i == ADDR_W'(CLAIM_OFS));

  // R6: an idle claim returns zero
  p_idle_claim_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (claim_rd && !eip_o) |=> (rdata_o == '0));

  // R6: a claim with a request pending returns a legal ID
  p_claim_legal_id_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (claim_rd && eip_o && !claim_wr) |=>
      ((rdata_o != '0) && (rdata_o <= DATA_W'(NSRC))));

  // R7: a claimed input never shows as pending
  p_claimed_not_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((clm & pend) == '0));

  // R8: ownership is only released by a completion write
  p_hold_until_complete_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !claim_wr |=> (($past(clm) & ~clm) == '0));

  // R9: the top threshold blocks every request
  p_top_threshold_masks_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (thr_q == {PRIO_W{1'b1}}) |-> !eip_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .re_i    (re_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .eip_o   (eip_o),
  .pend    (pend),
  .clm     (clm),
  .thr_q   (thr_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk, rst_n, we, re, eip;
  logic [30:0] src;
  logic [15:0] addr;
  logic [31:0] wdata, rdata, got;
  int checks, failures;
  bit done;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata), .eip_o(eip)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  function automatic int pf(input int id);
    return (id * 3) % 8;
  endfunction

  initial begin
    #2ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:1] model;
    int exp;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; we = 0; re = 0; src = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 eip", {31'b0, eip}, 0);
    rd(16'h3000, got); chk("R1 thr", got, 0);
    rd(16'h1000, got); chk("R1 pend", got, 0);
    rd(16'h2000, got); chk("R1 en", got, 0);
    rd(16'h0014, got); chk("R1 prio5", got, 0);
    rd(16'h3004, got); chk("R1 claim", got, 0);

    // R2: priority and threshold readback
    for (int i = 1; i <= 31; i++) wr(16'(4*i), 32'hFFFF_FFF8 | 32'(i % 8));
    for (int i = 1; i <= 31; i++) begin
      rd(16'(4*i), got); chk("R2 prio", got, 32'(i % 8));
    end
    wr(16'h3000, 32'h5); rd(16'h3000, got); chk("R2 thr", got, 5);
    wr(16'h3000, 32'h0);

    // R10: unmapped reads
    rd(16'h0000, got); chk("R10 slot0", got, 0);
    rd(16'h0080, got); chk("R10 above", got, 0);
    rd(16'h0006, got); chk("R10 misalign", got, 0);
    rd(16'h1004, got); chk("R10 pend+4", got, 0);
    rd(16'h2004, got); chk("R10 en+4", got, 0);
    rd(16'h3008, got); chk("R10 claim+4", got, 0);

    // R3: enable and pending words
    wr(16'h2000, 32'hFFFF_FFFF); rd(16'h2000, got); chk("R3 en", got, 32'hFFFF_FFFE);
    wr(16'h1000, 32'hFFFF_FFFF); rd(16'h1000, got); chk("R3 pend ro", got, 0);

    // R4: latch holds after the input falls
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); src[2] = 1'b0;
    repeat (2) @(negedge clk);
    rd(16'h1000, got); chk("R4 latched", got, 32'h8);

    // R5 R9: priority x threshold sweep on input 3 (held high)
    wr(16'h2000, 32'h8);
    @(negedge clk); src[2] = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 8; t++) begin
        wr(16'h000C, 32'(p)); wr(16'h3000, 32'(t));
        chk("R5 eip", {31'b0, eip}, (p > t) ? 1 : 0);
        rd(16'h3004, got); chk("R9 claim", got, (p > t) ? 3 : 0);
        if (p > t) begin
          chk("R7 eip held", {31'b0, eip}, 0);
          rd(16'h1000, got); chk("R7 pend clr", got, 0);
          rd(16'h3004, got); chk("R7 no repeat", got, 0);
          wr(16'h3004, 32'd3);
          @(negedge clk);
          rd(16'h1000, got); chk("R8 repend", got, 32'h8);
        end
      end
    end

    // R6: full drain with all inputs held high
    for (int i = 1; i <= 31; i++) wr(16'(4*i), 32'(pf(i)));
    wr(16'h3000, 0); wr(16'h2000, 32'hFFFF_FFFE);
    @(negedge clk); src = '1;
    repeat (2) @(negedge clk);
    model = '0;
    for (int n = 0; n < 40; n++) begin
      int bp;
      exp = 0; bp = 0;
      for (int i = 1; i <= 31; i++)
        if (!model[i] && pf(i) > bp) begin bp = pf(i); exp = i; end
      rd(16'h3004, got); chk("R6 order", got, 32'(exp));
      if (exp == 0) break;
      model[exp] = 1'b1;
    end
    chk("R7 all held eip", {31'b0, eip}, 0);
    rd(16'h1000, got); chk("R9 prio0 pending only", got,
      32'h0101_0100 | 32'h0000_0000);

    // R8: completing an unclaimed ID is ignored
    wr(16'h3004, 32'd8); @(negedge clk);
    rd(16'h3004, got); chk("R8 bogus complete", got, 0);
    wr(16'h3004, 32'd5); @(negedge clk);
    rd(16'h3004, got); chk("R8 release", got, 5);

    // R9: threshold 7 blocks, 6 lets priority 7 through
    wr(16'h3000, 32'd7); wr(16'h3004, 32'd13); @(negedge clk);
    chk("R9 thr7 eip", {31'b0, eip}, 0);
    rd(16'h3004, got); chk("R9 thr7 claim", got, 0);
    wr(16'h3000, 32'd6);
    chk("R9 thr6 eip", {31'b0, eip}, 1);
    rd(16'h3004, got); chk("R9 thr6 claim", got, 13);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule